// File: doc/BRIEF.md
# Wide Register Write Collector

This block sits between a narrow host register bus and a bank of registers wider than the bus. Control registers are 128 bits and buffer-table entries are 64 bits, but the host moves only `BUS_W` bits (32 or 64) per access. A wide write arrives as several beats. All beats except the last go into a collection buffer. The final beat commits the whole register in one clock edge, so logic downstream never sees a half-written value. A wide read works the other way: the first beat latches the full register into a shadow buffer, and the later beats are served from that copy, so every beat of one read belongs to the same value.

A set of doorbell registers takes single 32-bit writes that skip the collector entirely. A doorbell write that lands between the beats of a pending wide write does not disturb that write. Each doorbell write produces a one-cycle notification on the output. The address space is divided into pages of `2^PAGE_SHIFT` bytes. Every page holds a table of wide registers at a 16-byte stride and a group of doorbell slots. A separate region holds the 64-bit buffer-table entries at an 8-byte stride.

Top module: `wide_reg_collector`

## Requirements
- R1: A write to a wide-register beat other than the last changes nothing readable. The beat is only held in the collection buffer.
- R2: A write to the last beat commits all 128 bits in one edge. Byte offset 0 carries bits 31:0, offset 4 bits 63:32, offset 8 bits 95:64 and offset 12 bits 127:96.
- R3: Buffer-table entry i sits at SRAM_BASE + 8*i. Its lower dword is at offset 0 and is only buffered. Its upper dword is at offset 4 and commits all 64 bits. Other entries stay unchanged.
- R4: A read of beat 0 returns live data and captures the whole register into the shadow. Later beats return the captured value, even if the register was rewritten after the beat-0 read.
- R5: A read of a non-zero beat without a preceding beat-0 read returns the shadow as left by the last beat-0 read. The shadow is zero after reset.
- R6: A write at a doorbell slot (offset DB_BASE + 16*k in a page, k < NDB) stores the low 32 bits at once. On the next cycle db_fire pulses for one cycle, with db_sel = page*NDB + k and db_value equal to the data. The value can be read back at the same address.
- R7: A doorbell write between the beats of a pending wide write neither commits the wide register nor changes its collected beats.
- R8: The address of a paged register is page * 2^PAGE_SHIFT plus its offset in the page. The same offset in different pages selects different registers.
- R9: Wide register j of a page sits at page offset 16*j. Writing one entry leaves its neighbours unchanged.
- R10: If the last beat targets a register other than the one whose earlier beats were collected, the collected beats are committed to the last beat's register and seq_err is set. seq_err stays set until reset. The buffer is cleared after every commit, so beats not written before the next commit land as zero.
- R11: rd_valid is high in the cycle after each rd_en, with rdata held in a register. A read of an unmapped address returns zero. A write to an unmapped address has no effect.
- R12: After reset, all registers, doorbells and buffer-table entries read zero, and seq_err and db_fire are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write beat strobe |
| rd_en | input | 1 | Read beat strobe |
| addr | input | ADDR_W | Byte address of the beat |
| wdata | input | BUS_W | Write beat data |
| rdata | output | BUS_W | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| seq_err | output | 1 | Sticky flag for a last beat that targets a different register |
| db_fire | output | 1 | One-cycle pulse after a doorbell write |
| db_sel | output | DB_SEL_W | Doorbell index, page*NDB + slot |
| db_value | output | 32 | Value written to the doorbell |

## Verification
The bench builds the block with its defaults: a 32-bit bus, four pages of four wide registers and three doorbells each, and sixteen buffer-table entries. The 32-bit width gives four beats per wide register and two per table entry. That makes the buffered-but-invisible middle beats, a doorbell landing between DW1 and DW2, and the stale upper-beat read all reachable. Four pages let the bench show that page 2 and page 0 at the same offset stay separate, and that a doorbell index combines page and slot.

// File: rtl/wrc_pkg.sv
package wrc_pkg;

    localparam int WIDE_W = 128;
    localparam int SRAM_W = 64;
    localparam int DOOR_W = 32;
    localparam int IDX_W  = 8;

    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_WIDE = 2'd1,
        KIND_SRAM = 2'd2,
        KIND_DOOR = 2'd3
    } kind_e;

    typedef struct packed {
        kind_e            kind;
        logic [IDX_W-1:0] idx;
        logic [1:0]       beat;
        logic             last;
    } target_t;

    function automatic logic same_reg(target_t a, target_t b);
        return (a.kind == b.kind) && (a.idx == b.idx);
    endfunction

endpackage

// File: rtl/wrc_decode.sv
module wrc_decode
    import wrc_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int BUS_W      = 32,
    parameter int PAGE_SHIFT = 13,
    parameter int NPAGE      = 4,
    parameter int NREG       = 4,
    parameter int DB_BASE    = 256,
    parameter int NDB        = 3,
    parameter int SRAM_BASE  = 32768,
    parameter int NSRAM      = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output target_t           tgt
);
    localparam int BO          = $clog2(BUS_W / 8);
    localparam int WIDE_BEATS  = WIDE_W / BUS_W;
    localparam int SRAM_BEATS  = SRAM_W / BUS_W;
    localparam logic [31:0] PAGE_MASK = 32'((1 << PAGE_SHIFT) - 1);
    localparam logic [31:0] SRAM_LO   = 32'(SRAM_BASE);
    localparam logic [31:0] SRAM_HI   = 32'(SRAM_BASE + NSRAM * 8);
    localparam logic [31:0] WIDE_END  = 32'(NREG * 16);
    localparam logic [31:0] DB_LO     = 32'(DB_BASE);
    localparam logic [31:0] DB_HI     = 32'(DB_BASE + NDB * 16);
    localparam logic [31:0] NPAGE_L   = 32'(NPAGE);

    logic [31:0] a32, page, off, rel;

    always_comb begin
        a32  = 32'(addr);
        page = a32 >> PAGE_SHIFT;
        off  = a32 & PAGE_MASK;
        rel  = a32 - SRAM_LO;
        tgt  = '0;
        if (a32 >= SRAM_LO && a32 < SRAM_HI) begin
            tgt.kind = KIND_SRAM;
            tgt.idx  = IDX_W'(rel >> 3);
            tgt.beat = 2'(rel[2:0] >> BO);
            tgt.last = (tgt.beat == 2'(SRAM_BEATS - 1));
        end else if (page < NPAGE_L) begin
            if (off < WIDE_END) begin
                tgt.kind = KIND_WIDE;
                tgt.idx  = IDX_W'(page * 32'(NREG) + (off >> 4));
                tgt.beat = 2'(off[3:0] >> BO);
                tgt.last = (tgt.beat == 2'(WIDE_BEATS - 1));
            end else if (off >= DB_LO && off < DB_HI && off[3:0] == 4'd0) begin
                tgt.kind = KIND_DOOR;
                tgt.idx  = IDX_W'(page * 32'(NDB) + ((off - DB_LO) >> 4));
                tgt.beat = 2'd0;
                tgt.last = 1'b1;
            end
        end
    end

endmodule

// File: rtl/wrc_collector.sv
module wrc_collector
    import wrc_pkg::*;
#(
    parameter int BUS_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  target_t           tgt,
    input  logic [BUS_W-1:0]  wdata,
    output logic              commit_valid,
    output target_t           commit_tgt,
    output logic [WIDE_W-1:0] commit_data,
    output logic              seq_err
);
    localparam int SLOTS = WIDE_W / BUS_W;

    logic [WIDE_W-1:0] coll_q;
    logic              pend_q;
    target_t           ptgt_q;
    logic              err_q;
    logic              coll_hit;

    assign coll_hit     = wr_en && (tgt.kind == KIND_WIDE || tgt.kind == KIND_SRAM);
    assign commit_valid = coll_hit && tgt.last;
    assign commit_tgt   = tgt;
    assign seq_err      = err_q;

    // merge the incoming beat into the held beats
    always_comb begin
        commit_data = coll_q;
        for (int s = 0; s < SLOTS; s++) begin
            if (tgt.beat == 2'(s)) commit_data[s*BUS_W +: BUS_W] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            coll_q <= '0;
            pend_q <= 1'b0;
            ptgt_q <= '0;
            err_q  <= 1'b0;
        end else if (coll_hit) begin
            if (tgt.last) begin
                coll_q <= '0;
                pend_q <= 1'b0;
                if (pend_q && !same_reg(ptgt_q, tgt)) err_q <= 1'b1;
            end else begin
                coll_q <= commit_data;
                pend_q <= 1'b1;
                ptgt_q <= tgt;
            end
        end
    end

endmodule

// File: rtl/wrc_readback.sv
module wrc_readback
    import wrc_pkg::*;
#(
    parameter int BUS_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  target_t           tgt,
    input  logic [WIDE_W-1:0] live,
    input  logic [DOOR_W-1:0] door_val,
    output logic [BUS_W-1:0]  rdata,
    output logic              rd_valid
);
    localparam int SLOTS = WIDE_W / BUS_W;

    logic [WIDE_W-1:0] shadow_q;
    logic [BUS_W-1:0]  shadow_slot;

    always_comb begin
        shadow_slot = '0;
        for (int s = 0; s < SLOTS; s++) begin
            if (tgt.beat == 2'(s)) shadow_slot = shadow_q[s*BUS_W +: BUS_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            rdata    <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                case (tgt.kind)
                    KIND_WIDE, KIND_SRAM: begin
                        if (tgt.beat == 2'd0) begin
                            shadow_q <= live;
                            rdata    <= live[BUS_W-1:0];
                        end else begin
                            rdata <= shadow_slot;
                        end
                    end
                    KIND_DOOR: rdata <= BUS_W'(door_val);
                    default:   rdata <= '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/wide_reg_collector.sv
module wide_reg_collector
    import wrc_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int BUS_W      = 32,
    parameter int PAGE_SHIFT = 13,
    parameter int NPAGE      = 4,
    parameter int NREG       = 4,
    parameter int DB_BASE    = 256,
    parameter int NDB        = 3,
    parameter int SRAM_BASE  = 32768,
    parameter int NSRAM      = 16,
    localparam int NWIDE     = NPAGE * NREG,
    localparam int NDOOR     = NPAGE * NDB,
    localparam int DB_SEL_W  = $clog2(NDOOR)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [BUS_W-1:0]    wdata,
    output logic [BUS_W-1:0]    rdata,
    output logic                rd_valid,
    output logic                seq_err,
    output logic                db_fire,
    output logic [DB_SEL_W-1:0] db_sel,
    output logic [31:0]         db_value
);
    localparam int WIX_W = $clog2(NWIDE);
    localparam int SIX_W = $clog2(NSRAM);

    target_t           tgt;
    logic              commit_valid;
    target_t           commit_tgt;
    logic [WIDE_W-1:0] commit_data;
    logic              door_we;
    logic [WIDE_W-1:0] live;
    logic [DOOR_W-1:0] door_val;

    logic [WIDE_W-1:0] wide_q [NWIDE];
    logic [SRAM_W-1:0] sram_q [NSRAM];
    logic [DOOR_W-1:0] door_q [NDOOR];

    wrc_decode #(
        .ADDR_W(ADDR_W), .BUS_W(BUS_W), .PAGE_SHIFT(PAGE_SHIFT), .NPAGE(NPAGE),
        .NREG(NREG), .DB_BASE(DB_BASE), .NDB(NDB), .SRAM_BASE(SRAM_BASE), .NSRAM(NSRAM)
    ) u_decode (
        .addr(addr),
        .tgt (tgt)
    );

    wrc_collector #(.BUS_W(BUS_W)) u_collector (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .tgt         (tgt),
        .wdata       (wdata),
        .commit_valid(commit_valid),
        .commit_tgt  (commit_tgt),
        .commit_data (commit_data),
        .seq_err     (seq_err)
    );

    wrc_readback #(.BUS_W(BUS_W)) u_readback (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .tgt     (tgt),
        .live    (live),
        .door_val(door_val),
        .rdata   (rdata),
        .rd_valid(rd_valid)
    );

    assign door_we = wr_en && (tgt.kind == KIND_DOOR);

    always_comb begin
        live     = '0;
        door_val = door_q[tgt.idx[DB_SEL_W-1:0]];
        case (tgt.kind)
            KIND_WIDE: live = wide_q[tgt.idx[WIX_W-1:0]];
            KIND_SRAM: live = WIDE_W'(sram_q[tgt.idx[SIX_W-1:0]]);
            default:   live = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NWIDE; i++) wide_q[i] <= '0;
            for (int i = 0; i < NSRAM; i++) sram_q[i] <= '0;
            for (int i = 0; i < NDOOR; i++) door_q[i] <= '0;
            db_fire  <= 1'b0;
            db_sel   <= '0;
            db_value <= '0;
        end else begin
            if (commit_valid) begin
                if (commit_tgt.kind == KIND_WIDE)
                    wide_q[commit_tgt.idx[WIX_W-1:0]] <= commit_data;
                else
                    sram_q[commit_tgt.idx[SIX_W-1:0]] <= commit_data[SRAM_W-1:0];
            end
            db_fire <= door_we;
            if (door_we) begin
                door_q[tgt.idx[DB_SEL_W-1:0]] <= wdata[DOOR_W-1:0];
                db_sel   <= tgt.idx[DB_SEL_W-1:0];
                db_value <= wdata[DOOR_W-1:0];
            end
        end
    end

endmodule

// File: rtl/wrc_checker.sv
module wrc_checker (
    input logic clk,
    input logic rst,
    input logic wr_en,
    input logic rd_en,
    input logic rd_valid,
    input logic seq_err,
    input logic db_fire,
    input logic commit_valid,
    input logic door_we
);
    AST_COMMIT_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        commit_valid |-> wr_en); // R2

    AST_DOOR_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
        door_we |-> !commit_valid); // R7

    AST_DB_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        db_fire |-> $past(wr_en)); // R6

    AST_RD_VALID_LAG: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_en) && !$past(rst)) |-> rd_valid); // R11

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        ($past(seq_err) && !$past(rst)) |-> seq_err); // R10

    AST_ERR_FROM_COMMIT: assert property (@(posedge clk) disable iff (rst)
        ($rose(seq_err) && !$past(rst)) |-> $past(commit_valid)); // R10

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!seq_err && !db_fire && !rd_valid)); // R12
endmodule

bind wide_reg_collector wrc_checker u_wrc_checker (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .rd_valid    (rd_valid),
    .seq_err     (seq_err),
    .db_fire     (db_fire),
    .commit_valid(commit_valid),
    .door_we     (door_we)
);

// File: tb/wide_reg_collector_bench.sv
module wide_reg_collector_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rd_valid;
    logic        seq_err;
    logic        db_fire;
    logic [3:0]  db_sel;
    logic [31:0] db_value;

    int n_vec = 0;
    int n_fail = 0;
    bit done = 0;
    logic last_rv;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wide_reg_collector u_wide_reg_collector (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .seq_err(seq_err),
        .db_fire(db_fire), .db_sel(db_sel), .db_value(db_value)
    );

    task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [15:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata; last_rv = rd_valid;
    endtask

    task automatic wr_wide(logic [15:0] base, logic [127:0] v);
        for (int b = 0; b < 4; b++) wr(base + 16'(4 * b), v[32*b +: 32]);
    endtask

    task automatic rd_wide(logic [15:0] base, output logic [127:0] v);
        logic [31:0] d;
        for (int b = 0; b < 4; b++) begin
            rd(base + 16'(4 * b), d);
            v[32*b +: 32] = d;
        end
    endtask

    task automatic t_reset();
        logic [31:0] d; logic [127:0] v;
        chk("R12 seq_err", 128'(seq_err), 0);
        chk("R12 db_fire", 128'(db_fire), 0);
        chk("R11 rd_valid idle", 128'(rd_valid), 0);
        rd(16'h0004, d); chk("R5 shadow zero at reset", 128'(d), 0);
        rd_wide(16'h6030, v); chk("R12 wide reg zero", v, 0);
        rd(16'h2100, d); chk("R12 doorbell zero", 128'(d), 0);
        rd(16'h8078, d); chk("R12 sram zero", 128'(d), 0);
    endtask

    task automatic t_buffered();
        logic [127:0] v;
        logic [127:0] x = 128'h44443333_22221111_BBBBAAAA_DDDDCCCC;
        for (int b = 0; b < 3; b++) wr(16'h0010 + 16'(4 * b), x[32*b +: 32]);
        rd_wide(16'h0010, v); chk("R1 no update before last beat", v, 0);
        wr(16'h001C, x[127:96]);
        rd_wide(16'h0010, v); chk("R2 full commit on last beat", v, x);
        rd_wide(16'h0000, v); chk("R9 entry 0 untouched", v, 0);
        rd_wide(16'h0020, v); chk("R9 entry 2 untouched", v, 0);
    endtask

    task automatic t_paging();
        logic [127:0] v;
        logic [127:0] y = 128'h0F0E0D0C_0B0A0908_07060504_03020100;
        wr_wide(16'h4010, y);
        rd_wide(16'h4010, v); chk("R8 page 2 entry 1", v, y);
        rd_wide(16'h0010, v);
        chk("R8 page 0 entry 1 kept", v, 128'h44443333_22221111_BBBBAAAA_DDDDCCCC);
    endtask

    task automatic t_sram();
        logic [31:0] d;
        wr(16'h8028, 32'hCAFE0001);
        rd(16'h8028, d); chk("R3 lower dword only buffered", 128'(d), 0);
        wr(16'h802C, 32'hBEEF0002);
        rd(16'h8028, d); chk("R3 entry 5 low", 128'(d), 128'hCAFE0001);
        rd(16'h802C, d); chk("R3 entry 5 high", 128'(d), 128'hBEEF0002);
        rd(16'h8020, d); chk("R3 entry 4 untouched", 128'(d), 0);
    endtask

    task automatic t_shadow();
        logic [31:0] d; logic [127:0] v;
        logic [127:0] o = 128'h0F0E0D0C_0B0A0908_07060504_03020100;
        logic [127:0] n = 128'h99998888_77776666_55554444_33332222;
        rd(16'h4010, d); chk("R4 beat0 live", 128'(d), 128'(o[31:0]));
        wr_wide(16'h4010, n);
        rd(16'h4014, d); chk("R4 beat1 from snapshot", 128'(d), 128'(o[63:32]));
        rd(16'h4018, d); chk("R4 beat2 from snapshot", 128'(d), 128'(o[95:64]));
        rd(16'h401C, d); chk("R4 beat3 from snapshot", 128'(d), 128'(o[127:96]));
        rd_wide(16'h4010, v); chk("R4 fresh read sees new", v, n);
    endtask

    task automatic t_stale();
        logic [31:0] d;
        rd(16'h6038, d);
        chk("R5 stale shadow beat2", 128'(d), 128'h77776666);
    endtask

    task automatic t_doorbell();
        logic [31:0] d; logic [127:0] v;
        logic [127:0] z = 128'hD3D3D3D3_D2D2D2D2_D1D1D1D1_D0D0D0D0;
        wr(16'h2000, z[31:0]);
        wr(16'h2004, z[63:32]);
        wr(16'h2110, 32'h12345678);
        chk("R6 db_fire pulse", 128'(db_fire), 1);
        chk("R6 db_sel page1 slot1", 128'(db_sel), 4);
        chk("R6 db_value", 128'(db_value), 128'h12345678);
        rd(16'h2000, d); chk("R7 doorbell did not commit", 128'(d), 0);
        chk("R6 db_fire one cycle", 128'(db_fire), 0);
        wr(16'h2008, z[95:64]);
        wr(16'h200C, z[127:96]);
        rd_wide(16'h2000, v); chk("R7 collected beats intact", v, z);
        rd(16'h2110, d); chk("R6 doorbell readback", 128'(d), 128'h12345678);
        chk("R7 no sequence error", 128'(seq_err), 0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        wr(16'h0080, 32'hFFFFFFFF);
        rd(16'h0080, d);
        chk("R11 unmapped read zero", 128'(d), 0);
        chk("R11 rd_valid after read", 128'(last_rv), 1);
        rd(16'h0000, d); chk("R11 unmapped write ignored", 128'(d), 0);
    endtask

    task automatic t_mismatch();
        logic [127:0] v;
        wr(16'h0020, 32'hA0A0A0A0);
        wr(16'h0024, 32'hA1A1A1A1);
        wr(16'h0028, 32'hA2A2A2A2);
        wr(16'h003C, 32'hB3B3B3B3);
        rd_wide(16'h0030, v);
        chk("R10 commit to last-beat reg", v, 128'hB3B3B3B3_A2A2A2A2_A1A1A1A1_A0A0A0A0);
        rd_wide(16'h0020, v); chk("R10 first reg untouched", v, 0);
        chk("R10 seq_err set", 128'(seq_err), 1);
        wr(16'h002C, 32'hC3C3C3C3);
        rd_wide(16'h0020, v); chk("R10 collector cleared", v, 128'hC3C3C3C3 << 96);
        chk("R10 seq_err sticky", 128'(seq_err), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_buffered();
        t_paging();
        t_sram();
        t_shadow();
        t_stale();
        t_doorbell();
        t_unmapped();
        t_mismatch();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule